// File: doc/BRIEF.md
# Accumulator ALU with Selectable Carry Chaining

This block is the 8-bit arithmetic and logic stage of a small accumulator-style microcontroller. Each cycle in which `op_valid` is high it takes an operation code, the working-register value `w_in`, a file operand `f_in` and the current carry, digit-carry and zero flags. At the next rising clock edge it registers a result byte, the updated flags, a skip request and a flag that says whether the result goes to the file register or to W. The literal forms of the operations take their constant on `f_in`.

A static configuration input, `carry_plain`, selects how addition and subtraction treat the incoming carry. When it is 0 the carry is chained, so multi-byte sums and differences need no extra fix-up instructions. When it is 1 both operations ignore the incoming carry.

The register file, instruction decode and the write itself stay outside this block. Flags that an operation does not affect are copied from the inputs to the registered flag outputs, so the surrounding core can always write back all three.

Top module: `acc_alu`

## Requirements
- R1: During and after a synchronous active-high reset, and until the first accepted operation, `res_q`, all three flag outputs, `skip_q`, `wr_file_q` and `out_valid` are 0.
- R2: With `carry_plain`=1, add gives `f_in + w_in` modulo 256 and ignores `c_in`. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result byte is zero.
- R3: With `carry_plain`=0, add gives `f_in + w_in + c_in`. C and DC are the carries out of bits 7 and 3 of that three-term sum, and Z is set when the result byte is zero.
- R4: With `carry_plain`=1, subtract gives `f_in - w_in` and ignores `c_in`. C=1 means no borrow (f ≥ w), and DC=1 means no borrow from the low nibble.
- R5: With `carry_plain`=0, subtract gives `f_in - w_in - (1 - c_in)`. C and DC are the no-borrow indicators of that difference, for the whole byte and for the low nibble.
- R6: AND, OR and XOR (file and literal forms), complement, increment, decrement and move-file update only Z. C and DC are passed through from the inputs.
- R7: Rotate left gives `{f[6:0], c_in}` with C = f[7`]`. Rotate right gives `{c_in, f[7:1]}` with C = f[0]. DC and Z pass through.
- R8: Nibble swap, move-W-to-file, move-literal and the two increment/decrement-and-skip operations change no flags.
- R9: Increment-and-skip and decrement-and-skip raise `skip_q` exactly when their 8-bit result is zero. Every other operation leaves `skip_q` low.
- R10: Clear-W and clear-file give a zero result and set Z. C and DC pass through.
- R11: For file operations `wr_file_q` follows `dest_sel` (0 = W, 1 = file). Literal forms and clear-W always give 0. Move-W-to-file and clear-file always give 1.
- R12: Outputs update one clock after an accepted operation, and `out_valid` marks that cycle. In a cycle with `op_valid` low, `out_valid` drops and the result and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 5 | Operation code (package enumeration) |
| w_in | input | 8 | Working-register operand |
| f_in | input | 8 | File operand or literal |
| dest_sel | input | 1 | Destination bit for file operations |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| z_in | input | 1 | Current zero flag |
| carry_plain | input | 1 | 1 = add/subtract ignore carry, 0 = carry chained |
| res_q | output | 8 | Registered result |
| c_q | output | 1 | Registered carry flag |
| dc_q | output | 1 | Registered digit-carry flag |
| z_q | output | 1 | Registered zero flag |
| skip_q | output | 1 | Skip-next-instruction request |
| wr_file_q | output | 1 | 1 = write result to file, 0 = to W |
| out_valid | output | 1 | Registered outputs are fresh |

## Verification
The bench drives both carry modes with the incoming carry set and cleared. A design that mixed up the configuration polarity, or let `c_in` leak into plain arithmetic, gives a result that is off by one in exactly these cases. Nibble boundaries such as 0x0F+0x01 and 0x10-0x01 catch a digit carry that is taken from the wrong bit, or that has the borrow polarity inverted. The skip operations are run on 0xFF and 0x01 so that a skip test on the operand, or a skip that touches the flags, shows up. Operations that must leave flags alone are given flag inputs of mixed values, so a wrong flag mask shows up at the outputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_IOR   = 5'd3,
    OP_XOR   = 5'd4,
    OP_ANDK  = 5'd5,
    OP_IORK  = 5'd6,
    OP_XORK  = 5'd7,
    OP_MOVF  = 5'd8,
    OP_MOVWF = 5'd9,
    OP_MOVK  = 5'd10,
    OP_CLRF  = 5'd11,
    OP_CLRW  = 5'd12,
    OP_COMF  = 5'd13,
    OP_INCF  = 5'd14,
    OP_DECF  = 5'd15,
    OP_INCSZ = 5'd16,
    OP_DECSZ = 5'd17,
    OP_RLF   = 5'd18,
    OP_RRF   = 5'd19,
    OP_SWAP  = 5'd20
  } op_e;

  localparam int OP_W = 5;

  // flag update mask and destination decision for one operation
  typedef struct packed {
    logic upd_c;
    logic upd_dc;
    logic upd_z;
    logic use_arith;
    logic is_sub;
    logic may_skip;
    logic force_w;
    logic force_file;
  } ctl_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic              do_sub,
  input  logic              chain_on,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic              half_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HIGH_W = DATA_W - HALF_W;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [HALF_W:0]   lo_sum;
  logic [HIGH_W:0]   hi_sum;

  // subtraction is a + ~b + carry; carry 1 means no borrow
  assign b_eff = do_sub ? ~b_val : b_val;
  assign cin   = chain_on ? carry_in : do_sub;

  assign lo_sum = {1'b0, a_val[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                + {{HALF_W{1'b0}}, cin};
  assign hi_sum = {1'b0, a_val[DATA_W-1:HALF_W]} + {1'b0, b_eff[DATA_W-1:HALF_W]}
                + {{HIGH_W{1'b0}}, lo_sum[HALF_W]};

  assign sum       = {hi_sum[HIGH_W-1:0], lo_sum[HALF_W-1:0]};
  assign carry_out = hi_sum[HIGH_W];
  assign half_out  = lo_sum[HALF_W];
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] f_val,
  input  logic [DATA_W-1:0] w_val,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              rot_carry
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] swapped;

  genvar gi;
  generate
    for (gi = 0; gi < HALF_W; gi++) begin : g_swap
      assign swapped[gi]          = f_val[gi + HALF_W];
      assign swapped[gi + HALF_W] = f_val[gi];
    end
  endgenerate

  always_comb begin
    result    = '0;
    rot_carry = carry_in;
    unique case (op)
      OP_AND, OP_ANDK: result = f_val & w_val;
      OP_IOR, OP_IORK: result = f_val | w_val;
      OP_XOR, OP_XORK: result = f_val ^ w_val;
      OP_MOVF, OP_MOVK: result = f_val;
      OP_MOVWF:        result = w_val;
      OP_CLRF, OP_CLRW: result = '0;
      OP_COMF:         result = ~f_val;
      OP_INCF, OP_INCSZ: result = f_val + 1'b1;
      OP_DECF, OP_DECSZ: result = f_val - 1'b1;
      OP_RLF: begin
        result    = {f_val[DATA_W-2:0], carry_in};
        rot_carry = f_val[DATA_W-1];
      end
      OP_RRF: begin
        result    = {carry_in, f_val[DATA_W-1:1]};
        rot_carry = f_val[0];
      end
      OP_SWAP:         result = swapped;
      default:         result = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_ctl.sv
module acc_alu_ctl
  import acc_alu_pkg::*;
(
  input  op_e  op,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (op)
      OP_ADD: begin
        ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
        ctl.use_arith = 1'b1;
      end
      OP_SUB: begin
        ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1;
        ctl.use_arith = 1'b1; ctl.is_sub = 1'b1;
      end
      OP_AND, OP_IOR, OP_XOR, OP_MOVF, OP_COMF, OP_INCF, OP_DECF:
        ctl.upd_z = 1'b1;
      OP_ANDK, OP_IORK, OP_XORK: begin
        ctl.upd_z = 1'b1; ctl.force_w = 1'b1;
      end
      OP_MOVK:  ctl.force_w = 1'b1;
      OP_CLRW: begin
        ctl.upd_z = 1'b1; ctl.force_w = 1'b1;
      end
      OP_CLRF: begin
        ctl.upd_z = 1'b1; ctl.force_file = 1'b1;
      end
      OP_MOVWF: ctl.force_file = 1'b1;
      OP_INCSZ, OP_DECSZ: ctl.may_skip = 1'b1;
      OP_RLF, OP_RRF: ctl.upd_c = 1'b1;
      OP_SWAP: ctl = '0;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_sel,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] f_in,
  input  logic              dest_sel,
  input  logic              c_in,
  input  logic              dc_in,
  input  logic              z_in,
  input  logic              carry_plain,
  output logic [DATA_W-1:0] res_q,
  output logic              c_q,
  output logic              dc_q,
  output logic              z_q,
  output logic              skip_q,
  output logic              wr_file_q,
  output logic              out_valid
);
  op_e               op;
  ctl_t              ctl;
  logic [DATA_W-1:0] ar_sum;
  logic              ar_c;
  logic              ar_dc;
  logic [DATA_W-1:0] un_res;
  logic              un_c;
  logic [DATA_W-1:0] res_n;
  logic              c_n;
  logic              dc_n;
  logic              z_n;
  logic              skip_n;
  logic              wr_n;

  assign op = op_e'(op_sel);

  acc_alu_ctl u_ctl (
    .op  (op),
    .ctl (ctl)
  );

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_val     (f_in),
    .b_val     (w_in),
    .do_sub    (ctl.is_sub),
    .chain_on  (~carry_plain),
    .carry_in  (c_in),
    .sum       (ar_sum),
    .carry_out (ar_c),
    .half_out  (ar_dc)
  );

  acc_alu_unary #(.DATA_W(DATA_W)) u_unary (
    .op        (op),
    .f_val     (f_in),
    .w_val     (w_in),
    .carry_in  (c_in),
    .result    (un_res),
    .rot_carry (un_c)
  );

  always_comb begin
    res_n  = ctl.use_arith ? ar_sum : un_res;
    c_n    = ctl.upd_c  ? (ctl.use_arith ? ar_c : un_c) : c_in;
    dc_n   = ctl.upd_dc ? ar_dc : dc_in;
    z_n    = ctl.upd_z  ? (res_n == '0) : z_in;
    skip_n = ctl.may_skip & (res_n == '0);
    wr_n   = ctl.force_file | (dest_sel & ~ctl.force_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      c_q       <= 1'b0;
      dc_q      <= 1'b0;
      z_q       <= 1'b0;
      skip_q    <= 1'b0;
      wr_file_q <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= op_valid;
      if (op_valid) begin
        res_q     <= res_n;
        c_q       <= c_n;
        dc_q      <= dc_n;
        z_q       <= z_n;
        skip_q    <= skip_n;
        wr_file_q <= wr_n;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] w_in,
  input logic [DATA_W-1:0] f_in,
  input logic              c_in,
  input logic              dc_in,
  input logic              z_in,
  input logic              carry_plain,
  input logic [DATA_W-1:0] res_q,
  input logic              c_q,
  input logic              dc_q,
  input logic              z_q,
  input logic              skip_q,
  input logic              wr_file_q,
  input logic              out_valid
);
  // R2
  plain_add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_ADD && carry_plain)
      |=> res_q == DATA_W'($past(f_in) + $past(w_in)));

  // R7
  rotate_left_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_RLF)
      |=> (res_q[0] == $past(c_in) && c_q == $past(f_in[DATA_W-1])));

  // R8
  swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SWAP)
      |=> (c_q == $past(c_in) && dc_q == $past(dc_in) && z_q == $past(z_in)));

  // R9
  skip_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> res_q == '0);

  // R10
  clear_sets_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_CLRW || op_sel == OP_CLRF))
      |=> (res_q == '0 && z_q));

  // R11
  literal_to_w_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_MOVK || op_sel == OP_ANDK ||
                  op_sel == OP_IORK || op_sel == OP_XORK || op_sel == OP_CLRW))
      |=> !wr_file_q);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!out_valid && $stable(res_q) && $stable(z_q)));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  import acc_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [4:0] op_sel;
  logic [7:0] w_in, f_in;
  logic       dest_sel, c_in, dc_in, z_in, carry_plain;
  logic [7:0] res_q;
  logic       c_q, dc_q, z_q, skip_q, wr_file_q, out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .w_in(w_in), .f_in(f_in), .dest_sel(dest_sel), .c_in(c_in),
    .dc_in(dc_in), .z_in(z_in), .carry_plain(carry_plain),
    .res_q(res_q), .c_q(c_q), .dc_q(dc_q), .z_q(z_q),
    .skip_q(skip_q), .wr_file_q(wr_file_q), .out_valid(out_valid)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // expected behaviour written from the requirement list
  task automatic expect_of(input op_e op, input int w, input int f, input bit c,
                           input bit dc, input bit z, input bit d, input bit plain,
                           output int r, output bit ec, output bit edc,
                           output bit ez, output bit es, output bit ewr);
    int b;
    r = 0; ec = c; edc = dc; ez = z; es = 0; ewr = d;
    case (op)
      OP_ADD: begin
        b = plain ? 0 : int'(c);
        r = (f + w + b) % 256; ec = (f + w + b) > 255;
        edc = ((f % 16) + (w % 16) + b) > 15; ez = (r == 0);
      end
      OP_SUB: begin
        b = plain ? 0 : int'(!c);
        r = (f - w - b + 512) % 256; ec = f >= w + b;
        edc = (f % 16) >= (w % 16) + b; ez = (r == 0);
      end
      OP_AND:  begin r = f & w; ez = (r == 0); end
      OP_IOR:  begin r = f | w; ez = (r == 0); end
      OP_XOR:  begin r = f ^ w; ez = (r == 0); end
      OP_ANDK: begin r = f & w; ez = (r == 0); ewr = 0; end
      OP_IORK: begin r = f | w; ez = (r == 0); ewr = 0; end
      OP_XORK: begin r = f ^ w; ez = (r == 0); ewr = 0; end
      OP_MOVF: begin r = f; ez = (r == 0); end
      OP_MOVWF: begin r = w; ewr = 1; end
      OP_MOVK: begin r = f; ewr = 0; end
      OP_CLRF: begin r = 0; ez = 1; ewr = 1; end
      OP_CLRW: begin r = 0; ez = 1; ewr = 0; end
      OP_COMF: begin r = 255 - f; ez = (r == 0); end
      OP_INCF: begin r = (f + 1) % 256; ez = (r == 0); end
      OP_DECF: begin r = (f + 255) % 256; ez = (r == 0); end
      OP_INCSZ: begin r = (f + 1) % 256; es = (r == 0); end
      OP_DECSZ: begin r = (f + 255) % 256; es = (r == 0); end
      OP_RLF:  begin r = ((f * 2) % 256) + int'(c); ec = f >= 128; end
      OP_RRF:  begin r = (f / 2) + (c ? 128 : 0); ec = (f % 2) == 1; end
      OP_SWAP: begin r = ((f % 16) * 16) + (f / 16); end
      default: ;
    endcase
  endtask

  task automatic run_op(string req, op_e op, int w, int f, bit c, bit dc, bit z,
                        bit d, bit plain);
    int r; bit ec, edc, ez, es, ewr;
    @(negedge clk);
    op_valid = 1; op_sel = op; w_in = w[7:0]; f_in = f[7:0];
    c_in = c; dc_in = dc; z_in = z; dest_sel = d; carry_plain = plain;
    @(posedge clk); #1;
    expect_of(op, w, f, c, dc, z, d, plain, r, ec, edc, ez, es, ewr);
    check(req, {op.name(), " res"}, res_q, r);
    check(req, {op.name(), " C"}, c_q, ec);
    check(req, {op.name(), " DC"}, dc_q, edc);
    check(req, {op.name(), " Z"}, z_q, ez);
    check(req, {op.name(), " skip"}, skip_q, es);
    check(req, {op.name(), " dest"}, wr_file_q, ewr);
    check("R12", {op.name(), " valid"}, out_valid, 1);
  endtask

  task automatic t_reset();
    rst = 1; op_valid = 0; op_sel = '0; w_in = 8'hA5; f_in = 8'h5A;
    dest_sel = 1; c_in = 1; dc_in = 1; z_in = 1; carry_plain = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "res", res_q, 0);
    check("R1", "flags", {c_q, dc_q, z_q, skip_q, wr_file_q, out_valid}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1", "post-reset valid", out_valid, 0);
  endtask

  task automatic t_add_plain();
    run_op("R2", OP_ADD, 8'h01, 8'h0F, 1, 0, 1, 1, 1);
    run_op("R2", OP_ADD, 8'h01, 8'hFF, 0, 0, 0, 0, 1);
    run_op("R2", OP_ADD, 8'h22, 8'h11, 1, 1, 1, 1, 1);
  endtask

  task automatic t_add_chain();
    run_op("R3", OP_ADD, 8'h00, 8'hFF, 1, 0, 0, 1, 0);
    run_op("R3", OP_ADD, 8'h00, 8'hFF, 0, 1, 1, 1, 0);
    run_op("R3", OP_ADD, 8'h07, 8'h08, 1, 0, 0, 0, 0);
  endtask

  task automatic t_sub_plain();
    run_op("R4", OP_SUB, 8'h05, 8'h05, 0, 0, 0, 1, 1);
    run_op("R4", OP_SUB, 8'h01, 8'h10, 0, 1, 1, 1, 1);
    run_op("R4", OP_SUB, 8'h01, 8'h00, 1, 1, 1, 0, 1);
  endtask

  task automatic t_sub_chain();
    run_op("R5", OP_SUB, 8'h05, 8'h05, 0, 1, 1, 1, 0);
    run_op("R5", OP_SUB, 8'h05, 8'h05, 1, 0, 0, 1, 0);
    run_op("R5", OP_SUB, 8'h00, 8'h10, 0, 1, 0, 0, 0);
  endtask

  task automatic t_logic();
    run_op("R6", OP_AND,  8'hF0, 8'h0F, 1, 0, 0, 1, 1);
    run_op("R6", OP_IOR,  8'h30, 8'h03, 0, 1, 1, 0, 1);
    run_op("R6", OP_XOR,  8'hAA, 8'hAA, 1, 1, 0, 1, 0);
    run_op("R6", OP_ANDK, 8'hFF, 8'h81, 0, 1, 1, 1, 1);
    run_op("R6", OP_IORK, 8'h00, 8'h00, 1, 0, 0, 1, 1);
    run_op("R6", OP_XORK, 8'h0F, 8'hFF, 0, 0, 1, 1, 1);
    run_op("R6", OP_COMF, 8'h00, 8'hFF, 1, 1, 0, 1, 1);
    run_op("R6", OP_INCF, 8'h00, 8'hFF, 0, 1, 0, 0, 1);
    run_op("R6", OP_DECF, 8'h00, 8'h00, 1, 0, 1, 1, 1);
    run_op("R6", OP_MOVF, 8'h55, 8'h00, 1, 1, 0, 0, 1);
  endtask

  task automatic t_rotate();
    run_op("R7", OP_RLF, 8'h00, 8'h80, 1, 1, 0, 1, 1);
    run_op("R7", OP_RLF, 8'h00, 8'h41, 0, 0, 1, 0, 1);
    run_op("R7", OP_RRF, 8'h00, 8'h01, 0, 1, 1, 1, 1);
    run_op("R7", OP_RRF, 8'h00, 8'h02, 1, 0, 0, 1, 1);
  endtask

  task automatic t_no_flags();
    run_op("R8", OP_SWAP,  8'h00, 8'h3C, 1, 0, 1, 1, 1);
    run_op("R8", OP_MOVWF, 8'h00, 8'h77, 0, 1, 0, 0, 1);
    run_op("R8", OP_MOVK,  8'h99, 8'h00, 1, 1, 0, 1, 1);
  endtask

  task automatic t_skip();
    run_op("R9", OP_INCSZ, 8'h00, 8'hFF, 0, 1, 0, 1, 1);
    run_op("R9", OP_INCSZ, 8'h00, 8'hFE, 1, 0, 1, 1, 1);
    run_op("R9", OP_DECSZ, 8'h00, 8'h01, 1, 1, 0, 0, 1);
    run_op("R9", OP_DECSZ, 8'h00, 8'h00, 0, 0, 1, 0, 1);
    run_op("R9", OP_ADD,   8'h01, 8'hFF, 0, 0, 0, 1, 1);
  endtask

  task automatic t_clear_dest();
    run_op("R10", OP_CLRW, 8'hFF, 8'hFF, 1, 0, 0, 1, 1);
    run_op("R10", OP_CLRF, 8'hFF, 8'hFF, 0, 1, 0, 0, 0);
    run_op("R11", OP_MOVF, 8'h00, 8'h12, 0, 0, 0, 0, 1);
    run_op("R11", OP_ANDK, 8'hFF, 8'h12, 0, 0, 0, 1, 1);
  endtask

  task automatic t_idle_hold();
    run_op("R12", OP_MOVK, 8'h00, 8'h6B, 0, 0, 0, 0, 1);
    @(negedge clk);
    op_valid = 0; op_sel = OP_CLRW; f_in = 8'h00; z_in = 1; c_in = 1;
    @(posedge clk); #1;
    check("R12", "idle valid", out_valid, 0);
    check("R12", "idle res hold", res_q, 8'h6B);
    check("R12", "idle Z hold", z_q, 0);
    check("R12", "idle C hold", c_q, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add_plain();
    t_add_chain();
    t_sub_plain();
    t_sub_chain();
    t_logic();
    t_rotate();
    t_no_flags();
    t_skip();
    t_clear_dest();
    t_idle_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule